// File: doc/BRIEF.md
# GPIO Controller with Per-Line Interrupt Routing

This block is a register-mapped general-purpose I/O peripheral for up to 32 lines. Software reads the pin levels and writes an output latch. A direction register chooses, bit by bit, whether a pin is driven from the latch or left as an input. There is also one spare stored word with no effect on the pins.

Every line can raise an interrupt. Its behaviour is set by three per-line bits: an enable, a polarity and an edge/level selector. A routing byte per line sends the line to one of `NIRQ` interrupt wires, or to none. Each interrupt wire is the OR of all enabled, firing lines routed to it.

The bus is a plain word port with no handshake. A write takes effect on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`. The block has no valid/ready stream, so back-pressure does not apply.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, every register reads zero, except the routing bytes, which read 0x80 (unrouted). `pin_oe`, `pin_out` and `irq_out` are all zero.
- R2: `pin_out` follows the output latch at word offset 0x04. `pin_oe` follows the direction register at 0x08: 1 drives the pin, 0 leaves it an input. Both change on the clock edge after the write.
- R3: A read at 0x00 returns the pin levels after a two-flop synchroniser. A pin change is therefore visible after the second rising clock edge. Writes to 0x00 have no effect.
- R4: With edge bit 0, a line fires while its synchronised level is high if polarity is 1, and while it is low if polarity is 0.
- R5: With edge bit 1, a line fires for exactly one clock on a rising edge (polarity 1) or a falling edge (polarity 0). The pulse is seen after the second rising clock edge that follows the pin change.
- R6: A line contributes to an interrupt wire only while its bit in the enable register (0x0C) is 1.
- R7: The routing byte for line i sits in the word at 0x20 + 4*(i/4), at bits 8*(i%4)+7 down to 8*(i%4). Bits 4:0 hold the target wire index, and bit 7 set marks the line unrouted. An unrouted line, or one whose index is NIRQ or higher, never raises an interrupt. Each wire is the OR of its enabled, firing lines.
- R8: Polarity is at 0x10 and edge select at 0x14. 0x18 is a stored word with no other effect. Bits 6:5 of every routing byte read zero. Unused addresses read zero and ignore writes.
- R9: Register bits for lines at or above `NLINES`, and routing bytes for such lines, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 8 | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | NLINES | Pin levels, asynchronous |
| pin_out | output | NLINES | Output latch to pads |
| pin_oe | output | NLINES | Pad drive enable |
| irq_out | output | NIRQ | Interrupt wires |

## Verification
The hardest case to reach is two lines routed to the same wire, with different trigger modes, firing in overlapping cycles. The same stress arises when a routing byte is rewritten while an edge pulse is in flight. Directed steps first set up level-high, level-low, rising, falling, unrouted and out-of-range routing on separate lines. A random phase then toggles all pins and rewrites enables, polarities, edge bits and routing words at random. A behavioural model holds the pin history and register contents and is compared against every output on every clock, so overlaps and mid-pulse reconfiguration are covered.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // word indices (byte address >> 2)
  localparam int W_DATA = 0;
  localparam int W_OUT  = 1;
  localparam int W_DIR  = 2;
  localparam int W_MASK = 3;
  localparam int W_POL  = 4;
  localparam int W_EDGE = 5;
  localparam int W_SPARE = 6;
  localparam int W_ROUTE0 = 8;
  localparam int IDX_W = 5;
  localparam logic [31:0] ROUTE_DEAD_BITS = 32'h6060_6060;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [NLINES-1:0]        in_sync,
  output logic [NLINES-1:0]        out_q,
  output logic [NLINES-1:0]        dir_q,
  output logic [NLINES-1:0]        mask_q,
  output logic [NLINES-1:0]        pol_q,
  output logic [NLINES-1:0]        edge_q,
  output logic [NLINES-1:0]        route_off,
  output logic [NLINES*IDX_W-1:0]  route_idx
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] A_DATA  = WORD_W'(W_DATA);
  localparam logic [WORD_W-1:0] A_OUT   = WORD_W'(W_OUT);
  localparam logic [WORD_W-1:0] A_DIR   = WORD_W'(W_DIR);
  localparam logic [WORD_W-1:0] A_MASK  = WORD_W'(W_MASK);
  localparam logic [WORD_W-1:0] A_POL   = WORD_W'(W_POL);
  localparam logic [WORD_W-1:0] A_EDGE  = WORD_W'(W_EDGE);
  localparam logic [WORD_W-1:0] A_SPARE = WORD_W'(W_SPARE);

  logic [WORD_W-1:0] word;
  logic [NLINES-1:0] spare_q;
  logic              unused_bits;

  assign word        = bus_addr[ADDR_W-1:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata & ROUTE_DEAD_BITS};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      mask_q  <= '0;
      pol_q   <= '0;
      edge_q  <= '0;
      spare_q <= '0;
    end else if (bus_we) begin
      case (word)
        A_OUT:   out_q   <= bus_wdata[NLINES-1:0];
        A_DIR:   dir_q   <= bus_wdata[NLINES-1:0];
        A_MASK:  mask_q  <= bus_wdata[NLINES-1:0];
        A_POL:   pol_q   <= bus_wdata[NLINES-1:0];
        A_EDGE:  edge_q  <= bus_wdata[NLINES-1:0];
        A_SPARE: spare_q <= bus_wdata[NLINES-1:0];
        default: ;
      endcase
    end
  end

  // one routing byte per line, four per word
  for (genvar i = 0; i < NLINES; i++) begin : g_route
    localparam logic [WORD_W-1:0] RW = WORD_W'(W_ROUTE0 + i / 4);
    localparam int BP = 8 * (i % 4);
    logic             off_r;
    logic [IDX_W-1:0] idx_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_r <= 1'b1;
        idx_r <= '0;
      end else if (bus_we && word == RW) begin
        off_r <= bus_wdata[BP+7];
        idx_r <= bus_wdata[BP +: IDX_W];
      end
    end
    assign route_off[i]                 = off_r;
    assign route_idx[i*IDX_W +: IDX_W]  = idx_r;
  end

  always_comb begin
    bus_rdata = '0;
    case (word)
      A_DATA:  bus_rdata = 32'(in_sync);
      A_OUT:   bus_rdata = 32'(out_q);
      A_DIR:   bus_rdata = 32'(dir_q);
      A_MASK:  bus_rdata = 32'(mask_q);
      A_POL:   bus_rdata = 32'(pol_q);
      A_EDGE:  bus_rdata = 32'(edge_q);
      A_SPARE: bus_rdata = 32'(spare_q);
      default: begin
        for (int j = 0; j < NLINES; j++) begin
          if (word == WORD_W'(W_ROUTE0 + j / 4)) begin
            bus_rdata[8*(j%4)+7]         = route_off[j];
            bus_rdata[8*(j%4) +: IDX_W]  = route_idx[j*IDX_W +: IDX_W];
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pin_in,
  input  logic [NLINES-1:0] pol,
  input  logic [NLINES-1:0] edge_sel,
  output logic [NLINES-1:0] level_sync,
  output logic [NLINES-1:0] hit
);
  logic [NLINES-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_sync = sync_q;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic rise, fall;
    assign rise = sync_q[i] & ~prev_q[i];
    assign fall = ~sync_q[i] & prev_q[i];
    always_comb begin
      if (edge_sel[i]) hit[i] = pol[i] ? rise : fall;
      else             hit[i] = pol[i] ? sync_q[i] : ~sync_q[i];
    end
  end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int NIRQ   = 4
) (
  input  logic [NLINES-1:0]       hit,
  input  logic [NLINES-1:0]       mask,
  input  logic [NLINES-1:0]       route_off,
  input  logic [NLINES*IDX_W-1:0] route_idx,
  output logic [NIRQ-1:0]         irq_out
);
  logic [NLINES-1:0] live;
  assign live = hit & mask & ~route_off;

  for (genvar k = 0; k < NIRQ; k++) begin : g_wire
    always_comb begin
      irq_out[k] = 1'b0;
      for (int i = 0; i < NLINES; i++) begin
        if (live[i] && route_idx[i*IDX_W +: IDX_W] == IDX_W'(k))
          irq_out[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int NIRQ   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic [NIRQ-1:0]   irq_out
);
  logic [NLINES-1:0]       level_sync, hit;
  logic [NLINES-1:0]       out_q, dir_q, mask_q, pol_q, edge_q, route_off;
  logic [NLINES*IDX_W-1:0] route_idx;

  gpio_irq_regs #(.NLINES(NLINES), .ADDR_W(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_sync(level_sync),
    .out_q(out_q), .dir_q(dir_q), .mask_q(mask_q), .pol_q(pol_q),
    .edge_q(edge_q), .route_off(route_off), .route_idx(route_idx)
  );

  gpio_line_detect #(.NLINES(NLINES)) u_detect (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pol(pol_q),
    .edge_sel(edge_q), .level_sync(level_sync), .hit(hit)
  );

  gpio_irq_route #(.NLINES(NLINES), .NIRQ(NIRQ)) u_route (
    .hit(hit), .mask(mask_q), .route_off(route_off),
    .route_idx(route_idx), .irq_out(irq_out)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk #(
  parameter int NLINES = 32,
  parameter int NIRQ   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [7:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NLINES-1:0] pin_oe,
  input logic [NIRQ-1:0]   irq_out,
  input logic [NLINES-1:0] mask_q,
  input logic [NLINES-1:0] pol_q,
  input logic [NLINES-1:0] edge_q,
  input logic [NLINES-1:0] hit
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && irq_out == '0));

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[7:2] == 6'd2) |=> pin_oe == $past(bus_wdata[NLINES-1:0]));

  assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(edge_q) && $stable(pol_q)) |-> ((hit & $past(hit) & edge_q) == '0));

  assert_masked_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_out) |-> (|(hit & mask_q)));
endmodule

bind gpio_irq_router gpio_irq_router_chk #(.NLINES(NLINES), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_oe(pin_oe), .irq_out(irq_out),
  .mask_q(mask_q), .pol_q(pol_q), .edge_q(edge_q), .hit(hit)
);

// File: tb/gpio_irq_router_bench.sv
module gpio_irq_router_bench;
  localparam int N = 18;
  localparam int K = 3;
  localparam logic [31:0] LMASK = 32'h0003_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_addr = 8'h00;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe;
  logic [K-1:0]  irq_out;

  gpio_irq_router #(.NLINES(N), .NIRQ(K)) u_gpio_irq_router (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_out, m_dir, m_mask, m_pol, m_edge, m_spare;
  logic        m_off [N];
  int          m_idx [N];
  logic [N-1:0] seen1, seen2, seen3; // pin samples one, two, three edges ago

  task automatic chk_eq(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(logic [7:0] a);
    int w = int'(a[7:2]);
    logic [31:0] r = '0;
    case (w)
      0: r = 32'(seen2);
      1: r = m_out;
      2: r = m_dir;
      3: r = m_mask;
      4: r = m_pol;
      5: r = m_edge;
      6: r = m_spare;
      default: begin
        if (w >= 8) begin
          for (int j = 0; j < 4; j++) begin
            int ln = 4 * (w - 8) + j;
            if (ln < N) begin
              r[8*j+7] = m_off[ln];
              r[8*j +: 5] = m_idx[ln][4:0];
            end
          end
        end
      end
    endcase
    return r;
  endfunction

  function automatic void m_write(logic [7:0] a, logic [31:0] d);
    int w = int'(a[7:2]);
    case (w)
      1: m_out = d & LMASK;
      2: m_dir = d & LMASK;
      3: m_mask = d & LMASK;
      4: m_pol = d & LMASK;
      5: m_edge = d & LMASK;
      6: m_spare = d & LMASK;
      default: begin
        if (w >= 8) begin
          for (int j = 0; j < 4; j++) begin
            int ln = 4 * (w - 8) + j;
            if (ln < N) begin
              m_off[ln] = d[8*j+7];
              m_idx[ln] = int'(d[8*j +: 5]);
            end
          end
        end
      end
    endcase
  endfunction

  function automatic logic [K-1:0] m_irq();
    logic [K-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      bit fire;
      if (m_edge[i]) fire = m_pol[i] ? (seen2[i] && !seen3[i]) : (!seen2[i] && seen3[i]);
      else           fire = m_pol[i] ? seen2[i] : !seen2[i];
      if (fire && m_mask[i] && !m_off[i] && m_idx[i] < K) r[m_idx[i]] = 1'b1;
    end
    return r;
  endfunction

  function automatic string addr_tag(logic [7:0] a);
    if (a[7:2] == 6'd0) return "R3";
    if (a[7:2] == 6'd1 || a[7:2] == 6'd2) return "R2";
    if (a[7:2] >= 6'd8 && a[7:2] <= 6'd12) return "R7";
    if (a[7:2] >= 6'd13) return "R9";
    return "R8";
  endfunction

  // cycle-by-cycle model update and comparison
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_out = '0; m_dir = '0; m_mask = '0; m_pol = '0; m_edge = '0; m_spare = '0;
      for (int i = 0; i < N; i++) begin m_off[i] = 1'b1; m_idx[i] = 0; end
      seen1 = '0; seen2 = '0; seen3 = '0;
    end else begin
      if (bus_we) m_write(bus_addr, bus_wdata);
      seen3 = seen2; seen2 = seen1; seen1 = pin_in;
    end
    #3;
    if (rst_n && !done) begin
      chk_eq("R2 pin_out", 32'(pin_out), m_out);
      chk_eq("R2 pin_oe", 32'(pin_oe), m_dir);
      chk_eq("R7 irq_out", 32'(irq_out), 32'(m_irq()));
      chk_eq(addr_tag(bus_addr), bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk); #3;
    chk_eq(tag, bus_rdata, exp);
  endtask

  task automatic tick_check_irq(int bit_i, logic exp, string tag);
    @(posedge clk); #3;
    chk_eq(tag, 32'(irq_out[bit_i]), 32'(exp));
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #3;
    // R1 reset state
    chk_eq("R1 irq after reset", 32'(irq_out), 32'h0);
    chk_eq("R1 oe after reset", 32'(pin_oe), 32'h0);
    rd(8'h20, 32'h8080_8080, "R1 routing reset");
    rd(8'h0C, 32'h0, "R1 mask reset");

    // R2 direction and output
    wr(8'h08, 32'h0003_00FF);
    wr(8'h04, 32'h0001_5555);
    @(posedge clk); #3;
    chk_eq("R2 pin_oe", 32'(pin_oe), 32'h0003_00FF);
    chk_eq("R2 pin_out", 32'(pin_out), 32'h0001_5555);

    // R9 bits above line count, R8 spare, unused, dead byte bits
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0003_FFFF, "R9 out upper bits");
    rd(8'h30, 32'h0000_8080, "R9 routing word beyond lines");
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0003_FFFF, "R8 spare word");
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, 32'h0, "R8 unused address");
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, 32'h0, "R8 unused high address");
    wr(8'h20, 32'h7F7F_7F7F);
    rd(8'h20, 32'h1F1F_1F1F, "R8 routing dead bits");

    // R3 synchroniser latency, write ignored
    @(negedge clk); bus_addr = 8'h00; pin_in[7] = 1'b1;
    @(posedge clk); #3; chk_eq("R3 one edge", bus_rdata & 32'h80, 32'h0);
    @(posedge clk); #3; chk_eq("R3 two edges", bus_rdata & 32'h80, 32'h80);
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h80, "R3 write ignored");
    pin_in[7] = 1'b0;

    // routing: l0->0, l1->1, l2->2, l3->idx3 (>=NIRQ), l4 unrouted, l5->0
    wr(8'h20, 32'h0302_0100);
    wr(8'h24, 32'h0000_0081);
    wr(8'h10, 32'h0000_001D);
    wr(8'h14, 32'h0000_0024);

    // R6 masked line silent
    @(negedge clk); pin_in[0] = 1'b1;
    repeat (3) @(posedge clk); #3;
    chk_eq("R6 masked irq", 32'(irq_out), 32'h0);
    wr(8'h0C, 32'h0000_0001);
    tick_check_irq(0, 1'b1, "R4 level high fires");
    @(negedge clk); pin_in[0] = 1'b0;
    tick_check_irq(0, 1'b1, "R4 level high held one edge");
    tick_check_irq(0, 1'b0, "R4 level high released");

    // R4 level low on line 1
    wr(8'h0C, 32'h0000_0002);
    tick_check_irq(1, 1'b1, "R4 level low fires");
    @(negedge clk); pin_in[1] = 1'b1;
    @(posedge clk);
    tick_check_irq(1, 1'b0, "R4 level low released");

    // R7 unrouted and out-of-range index
    @(negedge clk); pin_in[3] = 1'b1; pin_in[4] = 1'b1;
    wr(8'h0C, 32'h0000_001B);
    repeat (3) @(posedge clk); #3;
    chk_eq("R7 unrouted lines silent", 32'(irq_out), 32'h0);

    // R5 rising edge on line 2
    wr(8'h0C, 32'h0000_0024);
    @(negedge clk); pin_in[2] = 1'b1;
    tick_check_irq(2, 1'b0, "R5 rise after one edge");
    tick_check_irq(2, 1'b1, "R5 rise pulse");
    tick_check_irq(2, 1'b0, "R5 rise pulse one cycle");

    // R5 falling edge on line 5, routed to wire 0
    @(negedge clk); pin_in[5] = 1'b1;
    repeat (3) @(posedge clk); #3;
    chk_eq("R5 rise ignored on falling line", 32'(irq_out[0]), 32'h0);
    @(negedge clk); pin_in[5] = 1'b0;
    tick_check_irq(0, 1'b0, "R5 fall after one edge");
    tick_check_irq(0, 1'b1, "R5 fall pulse");
    tick_check_irq(0, 1'b0, "R5 fall pulse one cycle");

    // R7 sharing: line 0 level-high and line 5 both on wire 0
    wr(8'h0C, 32'h0000_0021);
    @(negedge clk); pin_in[0] = 1'b1; pin_in[5] = 1'b1;
    @(posedge clk);
    tick_check_irq(0, 1'b1, "R7 shared wire");
    @(negedge clk); pin_in[5] = 1'b0;
    @(posedge clk);
    tick_check_irq(0, 1'b1, "R7 shared wire with pulse");

    // random phase: model compared every clock
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      pin_in = N'($urandom);
      if (($urandom % 4) == 0) begin
        int pick = int'($urandom % 16);
        bus_we = 1'b1;
        bus_addr = (pick == 15) ? 8'h44 : 8'(pick * 4);
        bus_wdata = $urandom;
        if (pick >= 8) bus_wdata = bus_wdata & 32'h8383_8383;
      end else begin
        bus_we = 1'b0;
        bus_addr = 8'(($urandom % 16) * 4);
      end
    end
    @(negedge clk); bus_we = 1'b0;
    @(posedge clk); #4;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule